// File: doc/BRIEF.md
# Elapsed Time Counter Pair

This block keeps two free-running time counts on a 25 MHz reference clock. The fraction counter reports how many reference cycles have passed within the current second. It moves in coarse steps: once every 16 reference cycles (640 ns) it gains 16, so its four lowest bits always read as zero. It returns to zero where the value would reach 25,000,000. In that same update the whole-second counter gains one. The whole-second counter therefore holds the number of complete seconds since the last cold reset. It is 32 bits wide and rolls over from 0xFFFFFFFF to 0.

Both values are registered outputs that a register interface reads directly. An asynchronous active-low cold reset restarts both counters and the step prescaler from zero. A test hook lets a bench or a production test place both counters near the wrap point, so that a rollover can be seen without waiting a full second.

A two-state controller governs the datapath. In state ST_RUN the prescaler runs and the counters advance. In state ST_LOAD the counters take the preload values on every cycle and the prescaler is held at zero. The transition RUN_TO_LOAD is taken when `load_req` is sampled high in ST_RUN. The transition LOAD_TO_RUN is taken when `load_req` is sampled low in ST_LOAD. The controller stays in ST_RUN while `load_req` is low and stays in ST_LOAD while it is high. Reset enters ST_RUN.

Top module: `elapsed_time_counter`

## Requirements
- R1: While `rst_n` is low, `frac_out` and `secs_out` are 0. After release, counting starts from 0 with the prescaler at 0.
- R2: In ST_RUN, the fraction count grows by 16 once every 16 clock cycles. Counting k edges from the reference edge (reset release, or the edge that loads the counters and returns to ST_RUN), the output after the k-th edge (k ≥ 1) carries floor((k-1)/16) updates.
- R3: Bits [3:0] of `frac_out` are always 0.
- R4: `frac_out` never exceeds 24,999,984. An update from 24,999,984 yields 0.
- R5: `secs_out` rises by exactly 1 in the same update that returns the fraction count to 0, and changes at no other time outside loading.
- R6: `secs_out` rolls over from 0xFFFFFFFF to 0 on a fraction wrap.
- R7: When `load_req` is sampled high, the controller enters ST_LOAD on that edge. On each later edge spent in ST_LOAD, both counters take the preload values and the prescaler clears. No counting happens in ST_LOAD. The outputs show the loaded values one edge after the load.
- R8: A fraction preload is stored with bits [3:0] forced to 0. A value whose masked form exceeds 24,999,984 is stored as 0. The seconds preload is stored unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| load_req | input | 1 | Test hook: request to preload the counters |
| load_frac | input | 32 | Fraction value to preload |
| load_secs | input | 32 | Seconds value to preload |
| frac_out | output | 32 | Registered sub-second count, in reference cycles |
| secs_out | output | 32 | Registered whole-second count |

## Verification
The results arrive on a fixed schedule measured from a reference edge.

- **Loading:** a `load_req` sampled at edge E1 moves the controller to ST_LOAD. The counters load at E2, and the outputs show the loaded values after E3.
- **Counting:** after k edges past the reference edge, the outputs carry floor((k-1)/16) updates, because the output register adds one cycle behind the counter.

The bench drives inputs on falling edges and counts exact edges from each reference point. It samples only on the following falling edge, so every expected value comes from that edge count.

// File: rtl/etc_pkg.sv
package etc_pkg;
    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_LOAD = 1'b1
    } etc_state_t;
endpackage

// File: rtl/etc_prescaler.sv
module etc_prescaler #(
    parameter int STEP = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic en,
    output logic tick
);
    localparam int PW = (STEP > 1) ? $clog2(STEP) : 1;
    localparam logic [PW-1:0] LAST_P = PW'(STEP - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clear) begin
            phase_q <= '0;
        end else if (en) begin
            phase_q <= (phase_q == LAST_P) ? '0 : phase_q + 1'b1;
        end
    end

    assign tick = en && !clear && (phase_q == LAST_P);
endmodule

// File: rtl/etc_frac_counter.sv
module etc_frac_counter #(
    parameter int REF_HZ = 25_000_000,
    parameter int STEP   = 16,
    parameter int W      = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic         wrap
);
    localparam logic [W-1:0] LAST_V = W'(REF_HZ - STEP);
    localparam logic [W-1:0] STEP_V = W'(STEP);

    logic at_last;
    assign at_last = (count >= LAST_V);
    assign wrap    = tick && !load && at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (tick) begin
            count <= at_last ? '0 : count + STEP_V;
        end
    end
endmodule

// File: rtl/etc_secs_counter.sv
module etc_secs_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/elapsed_time_counter.sv
module elapsed_time_counter
    import etc_pkg::*;
#(
    parameter int REF_HZ = 25_000_000,
    parameter int STEP   = 16,
    parameter int FRAC_W = 32,
    parameter int SECS_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    input  logic [FRAC_W-1:0] load_frac,
    input  logic [SECS_W-1:0] load_secs,
    output logic [FRAC_W-1:0] frac_out,
    output logic [SECS_W-1:0] secs_out
);
    localparam logic [FRAC_W-1:0] LOW_MASK = FRAC_W'(STEP - 1);
    localparam logic [FRAC_W-1:0] LAST_V   = FRAC_W'(REF_HZ - STEP);

    etc_state_t state_q, state_d;
    logic       load_en, cnt_en, tick, wrap;
    logic [FRAC_W-1:0] frac_masked, frac_ld, frac_cnt;
    logic [SECS_W-1:0] secs_cnt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: RUN_TO_LOAD / LOAD_TO_RUN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (load_req)  state_d = ST_LOAD;
            ST_LOAD: if (!load_req) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // State outputs
    always_comb begin
        load_en = 1'b0;
        cnt_en  = 1'b0;
        unique case (state_q)
            ST_RUN:  cnt_en  = 1'b1;
            ST_LOAD: load_en = 1'b1;
            default: cnt_en  = 1'b0;
        endcase
    end

    assign frac_masked = load_frac & ~LOW_MASK;
    assign frac_ld     = (frac_masked > LAST_V) ? '0 : frac_masked;

    etc_prescaler #(.STEP(STEP)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load_en),
        .en    (cnt_en),
        .tick  (tick)
    );

    etc_frac_counter #(.REF_HZ(REF_HZ), .STEP(STEP), .W(FRAC_W)) u_frac (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_en),
        .load_val (frac_ld),
        .tick     (tick),
        .count    (frac_cnt),
        .wrap     (wrap)
    );

    etc_secs_counter #(.W(SECS_W)) u_secs (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_en),
        .load_val (load_secs),
        .inc      (wrap),
        .count    (secs_cnt)
    );

    // Registered read values
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frac_out <= '0;
            secs_out <= '0;
        end else begin
            frac_out <= frac_cnt;
            secs_out <= secs_cnt;
        end
    end
endmodule

// File: rtl/etc_checker.sv
module etc_checker #(
    parameter int REF_HZ = 25_000_000,
    parameter int STEP   = 16,
    parameter int FRAC_W = 32,
    parameter int SECS_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_load,
    input logic [FRAC_W-1:0] frac_out,
    input logic [SECS_W-1:0] secs_out
);
    localparam logic [FRAC_W-1:0] LOW_MASK = FRAC_W'(STEP - 1);
    localparam logic [FRAC_W-1:0] LAST_V   = FRAC_W'(REF_HZ - STEP);
    localparam logic [FRAC_W-1:0] STEP_V   = FRAC_W'(STEP);

    logic       past_ok;
    logic [2:0] ld_hist;
    logic       quiet;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
            ld_hist <= '0;
        end else begin
            past_ok <= 1'b1;
            ld_hist <= {ld_hist[1:0], in_load};
        end
    end

    assign quiet = past_ok && !in_load && (ld_hist == 3'b000);

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_zero_R1: assert (frac_out == '0 && secs_out == '0)
                else $error("outputs not zero in reset");
        end
    end

    assert_low_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frac_out & LOW_MASK) == '0);

    assert_frac_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frac_out <= LAST_V);

    assert_frac_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |-> (frac_out == $past(frac_out) ||
                   frac_out == $past(frac_out) + STEP_V ||
                   frac_out == '0));

    assert_wrap_point_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && frac_out == '0 && $past(frac_out) != '0) |->
            ($past(frac_out) == LAST_V && secs_out == $past(secs_out) + 1'b1));

    assert_secs_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && secs_out != $past(secs_out)) |->
            (secs_out == $past(secs_out) + 1'b1 && frac_out == '0 &&
             $past(frac_out) == LAST_V));
endmodule

bind elapsed_time_counter etc_checker #(
    .REF_HZ (REF_HZ),
    .STEP   (STEP),
    .FRAC_W (FRAC_W),
    .SECS_W (SECS_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_load  (load_en),
    .frac_out (frac_out),
    .secs_out (secs_out)
);

// File: tb/sim_elapsed_time_counter.sv
`timescale 1ns/100ps
module sim_elapsed_time_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_req = 1'b0;
    logic [31:0] load_frac = '0;
    logic [31:0] load_secs = '0;
    logic [31:0] frac_out, secs_out;

    int n_run  = 0;
    int n_fail = 0;

    localparam logic [31:0] LAST = 32'd24_999_984;

    always #2.5 clk = ~clk;

    elapsed_time_counter u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_req  (load_req),
        .load_frac (load_frac),
        .load_secs (load_secs),
        .frac_out  (frac_out),
        .secs_out  (secs_out)
    );

    // {preload frac, preload secs, edges k, expected frac, expected secs}
    localparam int NV = 11;
    localparam logic [159:0] VEC [0:NV-1] = '{
        {32'd0,          32'd0,          32'd1,  32'd0,          32'd0},  // R7
        {32'd0,          32'd0,          32'd17, 32'd16,         32'd0},  // R2
        {32'd0,          32'd5,          32'd33, 32'd32,         32'd5},  // R2
        {32'd24_999_984, 32'd7,          32'd16, 32'd24_999_984, 32'd7},  // R2 edge
        {32'd24_999_984, 32'd7,          32'd17, 32'd0,          32'd8},  // R4 R5
        {32'd24_999_968, 32'd7,          32'd33, 32'd0,          32'd8},  // R4 R5
        {32'd24_999_968, 32'd7,          32'd49, 32'd16,         32'd8},  // R5
        {32'd24_999_984, 32'hFFFF_FFFF,  32'd17, 32'd0,          32'd0},  // R6
        {32'd100,        32'd9,          32'd1,  32'd96,         32'd9},  // R8 mask
        {32'd30_000_000, 32'd9,          32'd1,  32'd0,          32'd9},  // R8 range
        {32'd24_999_999, 32'd2,          32'd17, 32'd0,          32'd3}   // R8 R4
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Preload, then wait k edges past the load edge and sample on the falling edge
    task automatic preload_and_wait(input logic [31:0] f, input logic [31:0] s, input int k);
        @(negedge clk);
        load_req  = 1'b1;
        load_frac = f;
        load_secs = s;
        @(posedge clk);
        @(negedge clk);
        load_req = 1'b0;
        @(posedge clk);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int bad_low, bad_rng;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 frac in reset", frac_out, 32'd0);
        chk("R1 secs in reset", secs_out, 32'd0);
        rst_n = 1'b1;

        // R2 R3 R4: free run from reset, 1601 edges -> 100 updates
        bad_low = 0;
        bad_rng = 0;
        for (int i = 0; i < 1601; i++) begin
            @(negedge clk);
            if (frac_out[3:0] != 4'd0) bad_low++;
            if (frac_out > LAST) bad_rng++;
        end
        chk("R2 free run frac", frac_out, 32'd1600);
        chk("R2 free run secs", secs_out, 32'd0);
        chk("R3 low bits zero count", bad_low, 0);
        chk("R4 range violations", bad_rng, 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            logic [159:0] e;
            e = VEC[v];
            preload_and_wait(e[159:128], e[127:96], int'(e[95:64]));
            chk($sformatf("R2/R4/R5/R6/R8 vector %0d frac", v), frac_out, e[63:32]);
            chk($sformatf("R2/R4/R5/R6/R8 vector %0d secs", v), secs_out, e[31:0]);
        end

        // R7: held load stops counting
        @(negedge clk);
        load_req  = 1'b1;
        load_frac = 32'd48;
        load_secs = 32'd3;
        repeat (40) @(negedge clk);
        chk("R7 hold frac", frac_out, 32'd48);
        chk("R7 hold secs", secs_out, 32'd3);
        load_req = 1'b0;
        @(posedge clk);
        repeat (17) @(posedge clk);
        @(negedge clk);
        chk("R7 resume frac", frac_out, 32'd64);
        chk("R7 resume secs", secs_out, 32'd3);

        // R1: reset mid-run restarts both counts
        preload_and_wait(32'd24_999_984, 32'd77, 5);
        rst_n = 1'b0;
        #1;
        chk("R1 async reset frac", frac_out, 32'd0);
        chk("R1 async reset secs", secs_out, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (17) @(posedge clk);
        @(negedge clk);
        chk("R1 restart frac", frac_out, 32'd16);
        chk("R1 restart secs", secs_out, 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule